// File: doc/BRIEF.md
# Two-Step Register Write Enable Guard

This block protects a small register space from stray writes. An upstream serial slave hands it decoded bus events: a start or repeated start, each received byte, a stop, and an abort flag for frames that ended abnormally. The block parses each frame into a device select byte, one register address byte and the data bytes that follow. It keeps two volatile latches, a write enable and a register write enable, in a status register. Writes to that status register arm and disarm the latches. A write to the clock or control area is committed only when both latches are set, and only once the frame has ended with a stop.

A committed write appears as a single-cycle strobe that carries the start address, the byte count and the bytes themselves, for a register file downstream. A busy flag then covers the write cycle. That cycle is long for the non-volatile control bytes and short for the volatile clock bytes. A committed write consumes the register write enable, so each further change needs a fresh unlock. A frame that is aborted, cut by a repeated start or malformed commits nothing and leaves the latches as they were.

Top module: `regwr_guard`

## Requirements
- R1: After reset, wel, rwel, busy and commit_valid are all 0.
- R2: A write frame (select byte 8'hDE) to the status address (default 8'h0F) carrying exactly one byte 8'h02 sets wel and leaves rwel unchanged. The change is visible in the cycle after the clock edge that samples ev_stop.
- R3: A one-byte status write of 8'h06 sets both wel and rwel when wel is already 1. With wel at 0, or for any status byte other than 8'h00, 8'h02 or 8'h06, both latches stay unchanged.
- R4: A one-byte status write of 8'h00 clears both wel and rwel.
- R5: A protected write is committed when wel and rwel are both 1 and busy is 0. Two layouts qualify: exactly CLK_BYTES (8) bytes starting at CLK_BASE (8'h00), or 1 to CTL_BYTES (5) bytes lying wholly inside CTL_BASE..CTL_BASE+CTL_BYTES-1 (8'h08..8'h0C). On commit, commit_valid is 1 for one cycle, in the cycle after the stop edge. In that cycle commit_addr holds the first address, commit_len the byte count, commit_data byte i in bits 8i+7:8i, and commit_nv is 1 for the control area. At the same time rwel goes to 0 and wel stays 1.
- R6: A protected write that arrives while either latch is 0 is not committed, and both latches stay unchanged.
- R7: A write frame ended by ev_abort, or cut off by a repeated start, commits nothing and leaves rwel set. A later well-formed frame still commits.
- R8: A read frame (select byte 8'hDF) between the unlock steps has no effect on the latches or on the sequence.
- R9: A frame whose select byte is neither 8'hDE nor 8'hDF is ignored.
- R10: A write is dropped with no commit and no latch change when its address is undefined, when a clock write carries other than 8 bytes, when a control write runs past the area's end, or when a status write carries other than one byte.
- R11: busy is 1 from the commit_valid cycle onward. It lasts NV_CYCLES cycles after a control commit and BUF_CYCLES cycles after a clock commit.
- R12: A protected write whose stop arrives while busy is 1 is not committed, and rwel stays set. Status writes still act while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_abort | input | 1 | Frame ended abnormally |
| ev_byte | input | 1 | byte_in is valid this cycle |
| byte_in | input | 8 | Received byte |
| wel | output | 1 | Write enable latch |
| rwel | output | 1 | Register write enable latch |
| busy | output | 1 | Write cycle in progress |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_nv | output | 1 | Commit targets the non-volatile control area |
| commit_addr | output | 8 | First register address of the commit |
| commit_len | output | LEN_W (4) | Number of bytes committed |
| commit_data | output | 8*MAXB (64) | Committed bytes, byte 0 lowest |

## Verification
Every result here (latch changes, the commit strobe and the start of busy) is due exactly one cycle after the clock edge that samples ev_stop. Nothing appears earlier, because the parser only holds bytes until the frame ends. Each stimulus event is driven on a falling edge and held for one cycle. The bench then reads the outputs on the next falling edge, which is the single cycle in which commit_valid is high. For busy, the bench counts falling edges from the commit cycle until busy drops, and compares the count with NV_CYCLES or BUF_CYCLES.

// File: rtl/regwr_guard_pkg.sv
package regwr_guard_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_DEV,
      PS_ADDR,
      PS_DATA,
      PS_SKIP
   } pstate_e;

   localparam logic [7:0] SEL_WRITE = 8'hDE;
   localparam logic [7:0] SEL_READ  = 8'hDF;

   localparam logic [7:0] ST_CLEAR  = 8'h00;
   localparam logic [7:0] ST_ARM1   = 8'h02;
   localparam logic [7:0] ST_ARM2   = 8'h06;
endpackage

// File: rtl/regwr_frame_parser.sv
module regwr_frame_parser
   import regwr_guard_pkg::*;
#(
   parameter int MAXB = 8,
   parameter int CW   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_abort,
   input  logic              ev_byte,
   input  logic [7:0]        byte_in,
   output logic              frame_end,
   output logic [7:0]        fr_addr,
   output logic [CW-1:0]     fr_cnt,
   output logic [8*MAXB-1:0] fr_data
);
   localparam logic [CW-1:0] CNT_SAT = CW'(MAXB + 1);

   pstate_e st_q;
   logic    take_byte;

   assign take_byte = ev_byte && !ev_start && !ev_stop && !ev_abort;
   assign frame_end = ev_stop && !ev_abort && (st_q == PS_DATA) && (fr_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         fr_addr <= '0;
         fr_cnt  <= '0;
      end else if (ev_abort || ev_stop) begin
         st_q <= PS_IDLE;
      end else if (ev_start) begin
         st_q   <= PS_DEV;
         fr_cnt <= '0;
      end else if (ev_byte) begin
         case (st_q)
            PS_DEV:  st_q <= (byte_in == SEL_WRITE) ? PS_ADDR : PS_SKIP;
            PS_ADDR: begin
               fr_addr <= byte_in;
               fr_cnt  <= '0;
               st_q    <= PS_DATA;
            end
            PS_DATA: if (fr_cnt != CNT_SAT) fr_cnt <= fr_cnt + 1'b1;
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < MAXB; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q <= '0;
         else if (take_byte && st_q == PS_DATA && fr_cnt == CW'(g)) lane_q <= byte_in;
      end
      assign fr_data[8*g +: 8] = lane_q;
   end
endmodule

// File: rtl/regwr_latch_ctrl.sv
module regwr_latch_ctrl
   import regwr_guard_pkg::*;
#(
   parameter int CW        = 4,
   parameter int CLK_BASE  = 0,
   parameter int CLK_BYTES = 8,
   parameter int CTL_BASE  = 8,
   parameter int CTL_BYTES = 5,
   parameter int STAT_ADDR = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_end,
   input  logic [7:0]    fr_addr,
   input  logic [CW-1:0] fr_cnt,
   input  logic [7:0]    fr_byte0,
   input  logic          busy,
   output logic          wel,
   output logic          rwel,
   output logic          go,
   output logic          go_nv
);
   localparam int CTL_LAST = CTL_BASE + CTL_BYTES - 1;

   logic hit_stat, hit_clk, hit_ctl;
   int   a_i, c_i;

   always_comb begin
      a_i      = int'(fr_addr);
      c_i      = int'(fr_cnt);
      hit_stat = (a_i == STAT_ADDR) && (c_i == 1);
      hit_clk  = (a_i == CLK_BASE) && (c_i == CLK_BYTES);
      hit_ctl  = (a_i >= CTL_BASE) && (c_i >= 1) && (c_i <= CTL_BYTES)
                 && (a_i + c_i - 1 <= CTL_LAST);
      go       = frame_end && (hit_clk || hit_ctl) && wel && rwel && !busy;
      go_nv    = go && hit_ctl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else if (frame_end && hit_stat) begin
         case (fr_byte0)
            ST_CLEAR: begin
               wel  <= 1'b0;
               rwel <= 1'b0;
            end
            ST_ARM1: wel <= 1'b1;
            ST_ARM2: if (wel) rwel <= 1'b1;
            default: ;
         endcase
      end else if (go) begin
         rwel <= 1'b0;
      end
   end
endmodule

// File: rtl/regwr_cycle_timer.sv
module regwr_cycle_timer #(
   parameter int NV_CYCLES  = 2_000_000,
   parameter int BUF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_nv,
   input  logic start_vol,
   output logic busy
);
   localparam int TW = $clog2(NV_CYCLES + 1);

   logic [TW-1:0] cnt_q;
   logic          vol_load;

   if (BUF_CYCLES == 0) begin : g_vol_none
      assign vol_load = 1'b0;
   end else begin : g_vol_timed
      assign vol_load = start_vol;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_nv)       cnt_q <= TW'(NV_CYCLES);
      else if (vol_load)       cnt_q <= TW'(BUF_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/regwr_guard.sv
module regwr_guard #(
   parameter int CLK_BASE   = 0,
   parameter int CLK_BYTES  = 8,
   parameter int CTL_BASE   = 8,
   parameter int CTL_BYTES  = 5,
   parameter int STAT_ADDR  = 15,
   parameter int NV_CYCLES  = 2_000_000,
   parameter int BUF_CYCLES = 4,
   localparam int MAXB      = (CLK_BYTES > CTL_BYTES) ? CLK_BYTES : CTL_BYTES,
   localparam int LEN_W     = $clog2(MAXB + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_abort,
   input  logic              ev_byte,
   input  logic [7:0]        byte_in,
   output logic              wel,
   output logic              rwel,
   output logic              busy,
   output logic              commit_valid,
   output logic              commit_nv,
   output logic [7:0]        commit_addr,
   output logic [LEN_W-1:0]  commit_len,
   output logic [8*MAXB-1:0] commit_data
);
   if (CLK_BYTES < 1 || CTL_BYTES < 1) begin : g_bad_size
      $error("regwr_guard: area sizes must be at least one byte");
   end
   if (CLK_BASE + CLK_BYTES > 256 || CTL_BASE + CTL_BYTES > 256 || STAT_ADDR > 255) begin : g_bad_range
      $error("regwr_guard: areas must fit an 8-bit address");
   end
   if (CTL_BASE < CLK_BASE + CLK_BYTES && CLK_BASE < CTL_BASE + CTL_BYTES) begin : g_bad_overlap
      $error("regwr_guard: clock and control areas overlap");
   end
   if ((STAT_ADDR >= CLK_BASE && STAT_ADDR < CLK_BASE + CLK_BYTES) ||
       (STAT_ADDR >= CTL_BASE && STAT_ADDR < CTL_BASE + CTL_BYTES)) begin : g_bad_stat
      $error("regwr_guard: status address lies inside a data area");
   end
   if (NV_CYCLES < 1 || BUF_CYCLES < 0 || BUF_CYCLES > NV_CYCLES) begin : g_bad_timing
      $error("regwr_guard: need 1 <= NV_CYCLES and 0 <= BUF_CYCLES <= NV_CYCLES");
   end

   logic              frame_end;
   logic [7:0]        fr_addr;
   logic [LEN_W-1:0]  fr_cnt;
   logic [8*MAXB-1:0] fr_data;
   logic              go, go_nv;

   regwr_frame_parser #(.MAXB(MAXB), .CW(LEN_W)) u_parse (
      .clk(clk), .rst_n(rst_n),
      .ev_start(ev_start), .ev_stop(ev_stop), .ev_abort(ev_abort),
      .ev_byte(ev_byte), .byte_in(byte_in),
      .frame_end(frame_end), .fr_addr(fr_addr), .fr_cnt(fr_cnt), .fr_data(fr_data)
   );

   regwr_latch_ctrl #(
      .CW(LEN_W), .CLK_BASE(CLK_BASE), .CLK_BYTES(CLK_BYTES),
      .CTL_BASE(CTL_BASE), .CTL_BYTES(CTL_BYTES), .STAT_ADDR(STAT_ADDR)
   ) u_latch (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .fr_addr(fr_addr),
      .fr_cnt(fr_cnt), .fr_byte0(fr_data[7:0]), .busy(busy),
      .wel(wel), .rwel(rwel), .go(go), .go_nv(go_nv)
   );

   regwr_cycle_timer #(.NV_CYCLES(NV_CYCLES), .BUF_CYCLES(BUF_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_nv(go_nv), .start_vol(go && !go_nv), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_valid <= 1'b0;
         commit_nv    <= 1'b0;
         commit_addr  <= '0;
         commit_len   <= '0;
         commit_data  <= '0;
      end else begin
         commit_valid <= go;
         if (go) begin
            commit_nv   <= go_nv;
            commit_addr <= fr_addr;
            commit_len  <= fr_cnt;
            commit_data <= fr_data;
         end
      end
   end
endmodule

// File: rtl/regwr_guard_chk.sv
module regwr_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic ev_abort,
   input logic wel,
   input logic rwel,
   input logic busy,
   input logic commit_valid
);
   AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) rwel |-> wel); // R3
   AST_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) commit_valid |-> ($past(wel) && $past(rwel))); // R6
   AST_COMMIT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n) commit_valid |-> (!rwel && wel)); // R5
   AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) commit_valid |=> !commit_valid); // R5
   AST_BUSY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) commit_valid |-> busy); // R11
   AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) commit_valid |-> !$past(busy)); // R12
   AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) ev_abort |=> (wel == $past(wel) && rwel == $past(rwel))); // R7
endmodule

bind regwr_guard regwr_guard_chk u_chk (.*);

// File: tb/sim_regwr_guard.sv
`timescale 1ns/1ps
module sim_regwr_guard;
   localparam int NV  = 40;
   localparam int BUF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_start = 1'b0, ev_stop = 1'b0, ev_abort = 1'b0, ev_byte = 1'b0;
   logic [7:0]  byte_in = '0;
   logic        wel, rwel, busy, commit_valid, commit_nv;
   logic [7:0]  commit_addr;
   logic [3:0]  commit_len;
   logic [63:0] commit_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   regwr_guard #(.NV_CYCLES(NV), .BUF_CYCLES(BUF)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_abort(ev_abort), .ev_byte(ev_byte), .byte_in(byte_in),
      .wel(wel), .rwel(rwel), .busy(busy), .commit_valid(commit_valid),
      .commit_nv(commit_nv), .commit_addr(commit_addr), .commit_len(commit_len),
      .commit_data(commit_data)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
   endtask
   task automatic pulse_abort();
      @(negedge clk); ev_abort = 1'b1; @(negedge clk); ev_abort = 1'b0;
   endtask
   task automatic send(input logic [7:0] b);
      @(negedge clk); ev_byte = 1'b1; byte_in = b; @(negedge clk); ev_byte = 1'b0;
   endtask

   task automatic frame_open(input logic [7:0] dev, input logic [7:0] addr,
                             input int n, input logic [63:0] d);
      pulse_start();
      send(dev);
      send(addr);
      for (int i = 0; i < n; i++) send(d[8*i +: 8]);
   endtask

   // complete frame; outputs sampled on the negedge right after the stop edge
   task automatic frame(input logic [7:0] dev, input logic [7:0] addr,
                        input int n, input logic [63:0] d);
      frame_open(dev, addr, n, d);
      pulse_stop();
   endtask

   task automatic stat(input logic [7:0] v);
      frame(8'hDE, 8'h0F, 1, {56'h0, v});
   endtask

   task automatic unlock();
      stat(8'h02);
      stat(8'h06);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 wel", wel, 0);
      check("R1 rwel", rwel, 0);
      check("R1 busy", busy, 0);
      check("R1 commit_valid", commit_valid, 0);
   endtask

   task automatic t_unlock_steps();
      stat(8'h02);
      check("R2 wel after 02", wel, 1);
      check("R2 rwel after 02", rwel, 0);
      stat(8'h06);
      check("R3 wel after 06", wel, 1);
      check("R3 rwel after 06", rwel, 1);
      stat(8'h00);
      check("R4 wel cleared", wel, 0);
      check("R4 rwel cleared", rwel, 0);
      stat(8'h06);
      check("R3 06 without wel: rwel", rwel, 0);
      check("R3 06 without wel: wel", wel, 0);
      stat(8'h02);
      stat(8'h05);
      check("R3 odd value keeps wel", wel, 1);
      check("R3 odd value keeps rwel", rwel, 0);
      stat(8'h00);
   endtask

   task automatic t_ctl_commit();
      int n;
      unlock();
      frame(8'hDE, 8'h09, 3, 64'h0000_0000_00C3_B2A1);
      check("R5 commit_valid", commit_valid, 1);
      check("R5 commit_addr", commit_addr, 8'h09);
      check("R5 commit_len", commit_len, 3);
      check("R5 commit_data", commit_data[23:0], 24'hC3B2A1);
      check("R5 commit_nv", commit_nv, 1);
      check("R5 rwel consumed", rwel, 0);
      check("R5 wel kept", wel, 1);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check("R11 nv busy length", n, NV);
   endtask

   task automatic t_no_lock();
      stat(8'h00);
      stat(8'h02);
      frame(8'hDE, 8'h08, 2, 64'h1122);
      check("R6 no commit with rwel 0", commit_valid, 0);
      check("R6 wel unchanged", wel, 1);
      check("R6 rwel unchanged", rwel, 0);
   endtask

   task automatic t_abort();
      unlock();
      frame_open(8'hDE, 8'h08, 1, 64'h55);
      pulse_abort();
      check("R7 abort no commit", commit_valid, 0);
      check("R7 abort rwel kept", rwel, 1);
      frame_open(8'hDE, 8'h08, 2, 64'h6655);
      pulse_start();
      send(8'hDF);
      pulse_stop();
      check("R7 repeated start no commit", commit_valid, 0);
      check("R7 repeated start rwel kept", rwel, 1);
      frame(8'hDE, 8'h0C, 1, 64'h77);
      check("R7 later frame commits", commit_valid, 1);
      check("R7 later frame addr", commit_addr, 8'h0C);
      wait_idle();
   endtask

   task automatic t_read_between();
      stat(8'h00);
      stat(8'h02);
      frame(8'hDF, 8'h0F, 0, 64'h0);
      check("R8 read keeps wel", wel, 1);
      stat(8'h06);
      check("R8 unlock completes after read", rwel, 1);
   endtask

   task automatic t_foreign();
      frame(8'hA0, 8'h08, 1, 64'h99);
      check("R9 foreign select no commit", commit_valid, 0);
      check("R9 foreign select rwel kept", rwel, 1);
   endtask

   task automatic t_bad_layout();
      int n;
      frame(8'hDE, 8'h10, 1, 64'h01);
      check("R10 undefined addr", commit_valid, 0);
      frame(8'hDE, 8'h00, 4, 64'h04030201);
      check("R10 short clock write", commit_valid, 0);
      frame(8'hDE, 8'h0B, 3, 64'h030201);
      check("R10 control past end", commit_valid, 0);
      frame(8'hDE, 8'h0F, 2, 64'h0000);
      check("R10 two-byte status keeps wel", wel, 1);
      check("R10 two-byte status keeps rwel", rwel, 1);
      frame(8'hDE, 8'h00, 8, 64'h8877_6655_4433_2211);
      check("R5 clock commit", commit_valid, 1);
      check("R5 clock data", commit_data, 64'h8877_6655_4433_2211);
      check("R5 clock len", commit_len, 8);
      check("R5 clock nv flag", commit_nv, 0);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      check("R11 volatile busy length", n, BUF);
   endtask

   task automatic t_busy_block();
      unlock();
      frame(8'hDE, 8'h08, 1, 64'hAA);
      check("R12 first commit", commit_valid, 1);
      stat(8'h06);
      check("R12 status acts while busy", rwel, 1);
      check("R12 still busy", busy, 1);
      frame(8'hDE, 8'h08, 1, 64'hBB);
      check("R12 write ignored while busy", commit_valid, 0);
      check("R12 rwel kept", rwel, 1);
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unlock_steps();
      t_ctl_commit();
      t_no_lock();
      t_abort();
      t_read_between();
      t_foreign();
      t_bad_layout();
      t_busy_block();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1-run: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule